// File: doc/BRIEF.md
# Coalescing Network Interrupt Status Controller

This block keeps the interrupt state of a network controller: a 32-bit event status register, a 32-bit enable mask and one level interrupt line to the host. Internal sources post event bits, and the host clears them by writing a clear mask. The host can rewrite the enable mask and a 16-bit coalescing delay at any time. Bit 31 is reserved. Only eight event sources exist; every other bit in a request is dropped.

Events fall into two classes. Receive-complete, receive-descriptor, transmit-complete and transmit-descriptor events may be delayed. Software, transmit-idle, receive-overrun and receive-idle events are urgent. After a post, an enabled urgent event raises the line on the next cycle. If only delayable events are pending and enabled, the line rises a programmed number of cycles after the post. Several completions that arrive in that window share one interrupt. The line falls as soon as no enabled event is pending, and that also cancels any delay still counting.

Top module: `nic_irq_coalesce`

## Requirements
- R1: After reset, status_o, mask_o, irq_o, rsvd_err_o and unimpl_warn_o are all zero.
- R2: An accepted post ORs its implemented bits into the status. The implemented bits are 0 (receive complete), 1 (receive descriptor), 4, 5, 6, 7, 9 and 12 by default, which gives the mask 0x12F3. unimpl_warn_o pulses for one cycle after a post that carries any other bit of 30:0, and those bits are never stored.
- R3: An accepted clear removes its implemented bits from the status and leaves every other bit unchanged.
- R4: A post or clear with bit 31 set changes nothing. rsvd_err_o pulses for one cycle after it.
- R5: When a post and a clear arrive in the same cycle, the clear is applied first and then the post, so a bit named in both ends up set.
- R6: When a post leaves an urgent bit (4, 5, 9 or 12 by default) both pending and enabled, irq_o is high in the cycle after the post.
- R7: When a post leaves only delayable bits (0, 1, 6 and 7) pending and enabled, with the line low, irq_o rises exactly D cycles after the post edge, where D is the delay register value. D = 0 asserts on the next cycle.
- R8: Further delayable posts while a delay is counting neither restart nor lengthen it.
- R9: A post that brings in an enabled urgent bit while a delay is counting raises irq_o on the next cycle.
- R10: When status AND mask becomes zero, through a clear or a mask write, irq_o is low on the next cycle and any running delay is cancelled.
- R11: Only a post can raise the line. A mask write that enables an event already pending leaves irq_o low. Mask bit 31 always reads zero.
- R12: Writing the delay register affects only delays started later, never one already counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_valid_i | input | 1 | Event post strobe |
| post_bits_i | input | 32 | Event bits to set |
| clr_valid_i | input | 1 | Host clear strobe |
| clr_bits_i | input | 32 | Event bits to clear |
| mask_we_i | input | 1 | Enable-mask write strobe |
| mask_i | input | 32 | New enable mask |
| delay_we_i | input | 1 | Delay register write strobe |
| delay_i | input | 16 | Coalescing delay in cycles |
| status_o | output | 32 | Event status register |
| mask_o | output | 32 | Enable mask register |
| irq_o | output | 1 | Level interrupt to the host |
| rsvd_err_o | output | 1 | Reserved-bit access pulse |
| unimpl_warn_o | output | 1 | Unsupported-event post pulse |

## Verification
The properties that check status after a post or clear assume that no other operation arrives in the same cycle. The properties that check the urgent path assume that the mask is not written in that cycle. The stimulus drives one strobe per cycle everywhere except the single vector that tests a simultaneous post and clear, and no property covers that cycle. Strobes are driven half a cycle away from the sampling edge and held for exactly one edge, so each request is seen only once.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int ISR_W = 32;
  localparam int RSVD_BIT = ISR_W - 1;

  typedef enum logic [1:0] {CLS_NONE, CLS_DELAY, CLS_URGENT} irq_cls_e;

  function automatic irq_cls_e bit_class(input int i, input int swi, input int txidle,
                                         input int txdesc, input int txok,
                                         input int rxorn, input int rxidle);
    if (i == 0 || i == 1 || i == txdesc || i == txok) return CLS_DELAY;
    if (i == swi || i == txidle || i == rxorn || i == rxidle) return CLS_URGENT;
    return CLS_NONE;
  endfunction

  function automatic logic [ISR_W-1:0] class_mask(input irq_cls_e want, input int swi,
                                                  input int txidle, input int txdesc,
                                                  input int txok, input int rxorn,
                                                  input int rxidle);
    logic [ISR_W-1:0] m;
    m = '0;
    for (int i = 0; i < RSVD_BIT; i++)
      m[i] = (bit_class(i, swi, txidle, txdesc, txok, rxorn, rxidle) == want);
    return m;
  endfunction
endpackage

// File: rtl/nic_irq_filter.sv
module nic_irq_filter import nic_irq_pkg::*; #(
  parameter int SWI_POS    = 12,
  parameter int TXIDLE_POS = 9,
  parameter int TXDESC_POS = 7,
  parameter int TXOK_POS   = 6,
  parameter int RXORN_POS  = 5,
  parameter int RXIDLE_POS = 4
) (
  input  logic             post_valid_i,
  input  logic [ISR_W-1:0] post_bits_i,
  input  logic             clr_valid_i,
  input  logic [ISR_W-1:0] clr_bits_i,
  output logic             post_ok_o,
  output logic             clr_ok_o,
  output logic [ISR_W-1:0] post_set_o,
  output logic [ISR_W-1:0] clr_set_o,
  output logic             rsvd_hit_o,
  output logic             unimpl_hit_o,
  output logic [ISR_W-1:0] urgent_m_o
);
  logic [ISR_W-1:0] impl_m;

  for (genvar i = 0; i < ISR_W; i++) begin : g_cls
    if (i == RSVD_BIT) begin : g_rsvd
      assign impl_m[i]     = 1'b0;
      assign urgent_m_o[i] = 1'b0;
    end else begin : g_evt
      localparam irq_cls_e CLS = bit_class(i, SWI_POS, TXIDLE_POS, TXDESC_POS,
                                           TXOK_POS, RXORN_POS, RXIDLE_POS);
      assign impl_m[i]     = (CLS != CLS_NONE);
      assign urgent_m_o[i] = (CLS == CLS_URGENT);
    end
  end

  assign post_ok_o    = post_valid_i && !post_bits_i[RSVD_BIT];
  assign clr_ok_o     = clr_valid_i && !clr_bits_i[RSVD_BIT];
  assign post_set_o   = post_ok_o ? (post_bits_i & impl_m) : '0;
  assign clr_set_o    = clr_ok_o ? (clr_bits_i & impl_m) : '0;
  assign rsvd_hit_o   = (post_valid_i && post_bits_i[RSVD_BIT]) ||
                        (clr_valid_i && clr_bits_i[RSVD_BIT]);
  assign unimpl_hit_o = post_ok_o && |(post_bits_i & ~impl_m);
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs import nic_irq_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ISR_W-1:0] post_set_i,
  input  logic [ISR_W-1:0] clr_set_i,
  input  logic             rsvd_hit_i,
  input  logic             unimpl_hit_i,
  input  logic             mask_we_i,
  input  logic [ISR_W-1:0] mask_i,
  input  logic             delay_we_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [ISR_W-1:0] isr_q_o,
  output logic [ISR_W-1:0] imr_q_o,
  output logic [ISR_W-1:0] isr_d_o,
  output logic [ISR_W-1:0] imr_d_o,
  output logic [CNT_W-1:0] delay_q_o,
  output logic             err_q_o,
  output logic             warn_q_o
);
  // clear first, then post: a bit named by both survives
  assign isr_d_o = (isr_q_o & ~clr_set_i) | post_set_i;
  assign imr_d_o = mask_we_i ? {1'b0, mask_i[RSVD_BIT-1:0]} : imr_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q_o   <= '0;
      imr_q_o   <= '0;
      delay_q_o <= '0;
      err_q_o   <= 1'b0;
      warn_q_o  <= 1'b0;
    end else begin
      isr_q_o  <= isr_d_o;
      imr_q_o  <= imr_d_o;
      err_q_o  <= rsvd_hit_i;
      warn_q_o <= unimpl_hit_i;
      if (delay_we_i) delay_q_o <= delay_i;
    end
  end
endmodule

// File: rtl/nic_irq_timer.sv
module nic_irq_timer import nic_irq_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_ok_i,
  input  logic [ISR_W-1:0] pend_i,
  input  logic [ISR_W-1:0] urgent_m_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             any_pend, urgent_pend;

  assign any_pend    = |pend_i;
  assign urgent_pend = |(pend_i & urgent_m_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!any_pend) begin
      irq_o <= 1'b0;
      run_q <= 1'b0;
    end else if (post_ok_i && urgent_pend) begin
      irq_o <= 1'b1;
      run_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == ONE) begin
        irq_o <= 1'b1;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end else if (post_ok_i && !irq_o) begin
      if (delay_i == '0) begin
        irq_o <= 1'b1;
      end else begin
        run_q <= 1'b1;
        cnt_q <= delay_i;
      end
    end
  end
endmodule

// File: rtl/nic_irq_coalesce.sv
module nic_irq_coalesce import nic_irq_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int SWI_POS    = 12,
  parameter int TXIDLE_POS = 9,
  parameter int TXDESC_POS = 7,
  parameter int TXOK_POS   = 6,
  parameter int RXORN_POS  = 5,
  parameter int RXIDLE_POS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             post_valid_i,
  input  logic [ISR_W-1:0] post_bits_i,
  input  logic             clr_valid_i,
  input  logic [ISR_W-1:0] clr_bits_i,
  input  logic             mask_we_i,
  input  logic [ISR_W-1:0] mask_i,
  input  logic             delay_we_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [ISR_W-1:0] status_o,
  output logic [ISR_W-1:0] mask_o,
  output logic             irq_o,
  output logic             rsvd_err_o,
  output logic             unimpl_warn_o
);
  logic             post_ok, clr_ok, rsvd_hit, unimpl_hit;
  logic [ISR_W-1:0] post_set, clr_set, urgent_m, isr_d, imr_d;
  logic [CNT_W-1:0] delay_q;

  nic_irq_filter #(
    .SWI_POS(SWI_POS), .TXIDLE_POS(TXIDLE_POS), .TXDESC_POS(TXDESC_POS),
    .TXOK_POS(TXOK_POS), .RXORN_POS(RXORN_POS), .RXIDLE_POS(RXIDLE_POS)
  ) u_filter (
    .post_valid_i (post_valid_i),
    .post_bits_i  (post_bits_i),
    .clr_valid_i  (clr_valid_i),
    .clr_bits_i   (clr_bits_i),
    .post_ok_o    (post_ok),
    .clr_ok_o     (clr_ok),
    .post_set_o   (post_set),
    .clr_set_o    (clr_set),
    .rsvd_hit_o   (rsvd_hit),
    .unimpl_hit_o (unimpl_hit),
    .urgent_m_o   (urgent_m)
  );

  nic_irq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .post_set_i   (post_set),
    .clr_set_i    (clr_set),
    .rsvd_hit_i   (rsvd_hit),
    .unimpl_hit_i (unimpl_hit),
    .mask_we_i    (mask_we_i),
    .mask_i       (mask_i),
    .delay_we_i   (delay_we_i),
    .delay_i      (delay_i),
    .isr_q_o      (status_o),
    .imr_q_o      (mask_o),
    .isr_d_o      (isr_d),
    .imr_d_o      (imr_d),
    .delay_q_o    (delay_q),
    .err_q_o      (rsvd_err_o),
    .warn_q_o     (unimpl_warn_o)
  );

  nic_irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .post_ok_i  (post_ok),
    .pend_i     (isr_d & imr_d),
    .urgent_m_i (urgent_m),
    .delay_i    (delay_q),
    .irq_o      (irq_o)
  );

  // clr_ok is folded into clr_set; kept for visibility in the checker
  logic clr_ok_unused;
  assign clr_ok_unused = clr_ok;
endmodule

// File: rtl/nic_irq_coalesce_chk.sv
module nic_irq_coalesce_chk import nic_irq_pkg::*; #(
  parameter logic [ISR_W-1:0] URGENT_M = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             post_valid_i,
  input logic [ISR_W-1:0] post_bits_i,
  input logic             clr_valid_i,
  input logic [ISR_W-1:0] clr_bits_i,
  input logic             mask_we_i,
  input logic [ISR_W-1:0] status_o,
  input logic [ISR_W-1:0] mask_o,
  input logic             irq_o,
  input logic             rsvd_err_o,
  input logic             unimpl_warn_o
);
  AST_STATUS_RSVD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[RSVD_BIT] && !mask_o[RSVD_BIT]);  // R11

  AST_RSVD_POST_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && post_bits_i[RSVD_BIT] && !clr_valid_i) |=> $stable(status_o));  // R4

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_err_o |-> $past((post_valid_i && post_bits_i[RSVD_BIT]) ||
                         (clr_valid_i && clr_bits_i[RSVD_BIT])));  // R4

  AST_WARN_AFTER_POST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_warn_o |-> $past(post_valid_i));  // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && !clr_bits_i[RSVD_BIT] && !post_valid_i) |=>
      ((status_o & $past(clr_bits_i)) == '0));  // R3

  AST_URGENT_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && !post_bits_i[RSVD_BIT] && !clr_valid_i && !mask_we_i &&
     |(post_bits_i & URGENT_M & mask_o)) |=> irq_o);  // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(status_o & mask_o));  // R10
endmodule

bind nic_irq_coalesce nic_irq_coalesce_chk #(
  .URGENT_M(nic_irq_pkg::class_mask(nic_irq_pkg::CLS_URGENT, SWI_POS, TXIDLE_POS,
                                    TXDESC_POS, TXOK_POS, RXORN_POS, RXIDLE_POS))
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .post_valid_i  (post_valid_i),
  .post_bits_i   (post_bits_i),
  .clr_valid_i   (clr_valid_i),
  .clr_bits_i    (clr_bits_i),
  .mask_we_i     (mask_we_i),
  .status_o      (status_o),
  .mask_o        (mask_o),
  .irq_o         (irq_o),
  .rsvd_err_o    (rsvd_err_o),
  .unimpl_warn_o (unimpl_warn_o)
);

// File: tb/nic_irq_coalesce_tb.sv
module nic_irq_coalesce_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        post_valid_i = 1'b0, clr_valid_i = 1'b0, mask_we_i = 1'b0, delay_we_i = 1'b0;
  logic [31:0] post_bits_i = '0, clr_bits_i = '0, mask_i = '0;
  logic [15:0] delay_i = '0;
  logic [31:0] status_o, mask_o;
  logic        irq_o, rsvd_err_o, unimpl_warn_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  nic_irq_coalesce dut_i (.*);

  typedef struct packed {
    logic        pv;
    logic [31:0] pb;
    logic        cv;
    logic [31:0] cb;
    logic [31:0] st;
    logic        err;
    logic        warn;
  } vec_t;

  // mask is zero throughout the table, so irq_o must stay low
  localparam vec_t VECS [11] = '{
    '{1'b1, 32'h0000_0001, 1'b0, 32'h0,          32'h0000_0001, 1'b0, 1'b0},
    '{1'b1, 32'h0000_0100, 1'b0, 32'h0,          32'h0000_0001, 1'b0, 1'b1},
    '{1'b1, 32'h0000_1030, 1'b0, 32'h0,          32'h0000_1031, 1'b0, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h0000_0010,  32'h0000_1021, 1'b0, 1'b0},
    '{1'b1, 32'h8000_0002, 1'b0, 32'h0,          32'h0000_1021, 1'b1, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h8000_1021,  32'h0000_1021, 1'b1, 1'b0},
    '{1'b1, 32'h0000_0002, 1'b1, 32'h0000_0002,  32'h0000_1023, 1'b0, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h7FFF_FFFF,  32'h0000_0000, 1'b0, 1'b0},
    '{1'b1, 32'h7FFF_FFFF, 1'b0, 32'h0,          32'h0000_12F3, 1'b0, 1'b1},
    '{1'b0, 32'h0,         1'b1, 32'h0000_0F00,  32'h0000_10F3, 1'b0, 1'b0},
    '{1'b0, 32'h0,         1'b1, 32'h7FFF_FFFF,  32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive for one edge, return at the following negedge
  task automatic op(input logic pv, input logic [31:0] pb, input logic cv,
                    input logic [31:0] cb, input logic mw, input logic [31:0] mv,
                    input logic dw, input logic [15:0] dv);
    post_valid_i = pv; post_bits_i = pb; clr_valid_i = cv; clr_bits_i = cb;
    mask_we_i = mw; mask_i = mv; delay_we_i = dw; delay_i = dv;
    @(posedge clk_i); #1;
    post_valid_i = 1'b0; clr_valid_i = 1'b0; mask_we_i = 1'b0; delay_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic post(input logic [31:0] b);  op(1, b, 0, 0, 0, 0, 0, 0); endtask
  task automatic clr(input logic [31:0] b);   op(0, 0, 1, b, 0, 0, 0, 0); endtask
  task automatic wmask(input logic [31:0] m); op(0, 0, 0, 0, 1, m, 0, 0); endtask
  task automatic wdly(input logic [15:0] d);  op(0, 0, 0, 0, 0, 0, 1, d); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk_i); endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 status", status_o, 32'h0);
    check("R1 mask", mask_o, 32'h0);
    check("R1 irq/err/warn", {29'h0, irq_o, rsvd_err_o, unimpl_warn_o}, 32'h0);

    // R2 R3 R4 R5 table
    for (int i = 0; i < 11; i++) begin
      op(VECS[i].pv, VECS[i].pb, VECS[i].cv, VECS[i].cb, 0, 0, 0, 0);
      check($sformatf("R2/R3/R4/R5 vec%0d status", i), status_o, VECS[i].st);
      check($sformatf("R4 vec%0d err", i), {31'h0, rsvd_err_o}, {31'h0, VECS[i].err});
      check($sformatf("R2 vec%0d warn", i), {31'h0, unimpl_warn_o}, {31'h0, VECS[i].warn});
      check($sformatf("R11 vec%0d irq", i), {31'h0, irq_o}, 32'h0);
    end

    // R11: enabling an already pending event does not raise the line
    post(32'h10);
    wmask(32'hFFFF_FFFF);
    idle(2);
    check("R11 no irq on mask write", {31'h0, irq_o}, 32'h0);
    check("R11 mask bit31", mask_o, 32'h7FFF_FFFF);
    clr(32'h7FFF_FFFF);

    // R6 / R10
    post(32'h1000);
    check("R6 urgent immediate", {31'h0, irq_o}, 32'h1);
    clr(32'h1000);
    check("R10 clear drops irq", {31'h0, irq_o}, 32'h0);

    // R7
    wdly(16'd5);
    post(32'h1);
    idle(4);
    check("R7 before delay", {31'h0, irq_o}, 32'h0);
    idle(1);
    check("R7 at delay", {31'h0, irq_o}, 32'h1);
    clr(32'h7FFF_FFFF);
    wdly(16'd0);
    post(32'h2);
    check("R7 zero delay", {31'h0, irq_o}, 32'h1);
    clr(32'h7FFF_FFFF);

    // R8
    wdly(16'd6);
    post(32'h1);
    idle(3);
    post(32'h40);
    idle(1);
    check("R8 not yet", {31'h0, irq_o}, 32'h0);
    idle(1);
    check("R8 no restart", {31'h0, irq_o}, 32'h1);
    clr(32'h7FFF_FFFF);

    // R12
    wdly(16'd8);
    post(32'h80);
    wdly(16'd1);
    idle(6);
    check("R12 old delay kept", {31'h0, irq_o}, 32'h0);
    idle(1);
    check("R12 fires at old delay", {31'h0, irq_o}, 32'h1);
    clr(32'h7FFF_FFFF);

    // R9
    wdly(16'd20);
    post(32'h1);
    idle(2);
    post(32'h20);
    check("R9 urgent cuts delay", {31'h0, irq_o}, 32'h1);

    // R10 through mask, R11 re-enable without post
    wmask(32'h0);
    check("R10 mask drops irq", {31'h0, irq_o}, 32'h0);
    wmask(32'h7FFF_FFFF);
    idle(3);
    check("R11 re-enable no irq", {31'h0, irq_o}, 32'h0);
    clr(32'h7FFF_FFFF);

    // R10 cancel
    wdly(16'd4);
    post(32'h1);
    idle(1);
    clr(32'h1);
    idle(5);
    check("R10 cancelled delay", {31'h0, irq_o}, 32'h0);
    post(32'h1);
    idle(3);
    check("R10 fresh delay early", {31'h0, irq_o}, 32'h0);
    idle(1);
    check("R10 fresh delay fires", {31'h0, irq_o}, 32'h1);
    check("R3 status", status_o, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule